// File: doc/BRIEF.md
# Edge-Filtered Status Summary Register

This block keeps track of a group of up to fifteen hardware status flags. Each clock it captures the live flags into a read-only condition word. A per-bit rising-edge mask and a per-bit falling-edge mask decide which flag changes are recorded. A recorded change sets a sticky bit in an event word. The event bit stays set until software reads the event word, and that read clears it.

An enable mask chooses which event bits count toward a single summary output. The summary output is meant to drive one status input of a register one level higher, so several of these blocks can be chained into a tree that ends in one interrupt-style flag. The top bit of every word is hard-wired to zero, so each word reads as a non-negative number.

Software reaches the words through a simple access port. The port has a strobe, a write flag, a 3-bit part selector and a data word. Read data is combinational from the selector. A write, or a clearing read of the event word, takes effect at the next rising clock edge.

Top module: `evt_status_reg`

## Requirements
- R1: The condition word equals `statusIn` with its top bit forced to zero, captured at each rising edge. A read of selector 0 therefore shows a new input value one edge after the input changes.
- R2: At an edge where a condition bit goes from 0 to 1 and the same-numbered rising-edge mask bit (selector 1) is 1, that event bit becomes 1.
- R3: At an edge where a condition bit goes from 1 to 0 and the same-numbered falling-edge mask bit (selector 2) is 1, that event bit becomes 1.
- R4: A change whose matching mask bit is 0 sets no event bit, and an edge on one bit affects no other bit.
- R5: An event bit, once set, stays set through later input changes until the event word is read.
- R6: A read of the event word (selector 3, `accEn`=1, `accWr`=0) returns the current value and clears the word at the following edge. A qualifying edge at that same edge still leaves its event bit set.
- R7: `sumOut` is 1 exactly when some event bit and its enable bit (selector 4) are both 1, and it follows a change of the enable mask at the edge that writes it.
- R8: After reset, the condition, falling-edge mask, enable and event words are 0, the rising-edge mask is 0x7FFF, and `sumOut` is 0.
- R9: Bit 15 reads as 0 in every word. Writing 1 to bit 15 of a mask or enable word leaves it 0.
- R10: Selector codes are 0 condition, 1 rising mask, 2 falling mask, 3 event, 4 enable. Codes 5 to 7 read as 0. Writes to codes 0, 3 and 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| statusIn | input | WIDTH | Live hardware status flags |
| accEn | input | 1 | Access strobe for the register port |
| accWr | input | 1 | 1 for a write, 0 for a read |
| accSel | input | 3 | Part selector, codes as in R10 |
| accWdata | input | WIDTH | Write data |
| accRdata | output | WIDTH | Read data of the selected part |
| sumOut | output | 1 | Enabled-event summary for the next level up |

## Verification
The bench looks hardest at the clearing read that coincides with a new qualifying edge. A design that clears after merging would lose that event, and the follow-up read would come back empty. It drives the top bit of both the inputs and the write data to 1, where a design that failed to mask that bit would report a spurious event or a raised summary. It also toggles flags whose masks are closed, between setting an event and reading it. A design that lets unfiltered edges through would show extra bits, and one that tracks the level instead of latching would lose the original bit. Finally, it reads the condition word in the same cycle the input changes and again one edge later, which exposes a design that is combinational or delayed by two stages.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_COND = 3'd0;
  localparam logic [SEL_W-1:0] SEL_RISE = 3'd1;
  localparam logic [SEL_W-1:0] SEL_FALL = 3'd2;
  localparam logic [SEL_W-1:0] SEL_EVT  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_ENA  = 3'd4;

  typedef struct packed {
    logic wrRise;
    logic wrFall;
    logic wrEna;
    logic clrEvt;
  } strobes_t;
endpackage

// File: rtl/evt_status_ctrl.sv
module evt_status_ctrl
  import evt_status_pkg::*;
(
  input  logic             accEn,
  input  logic             accWr,
  input  logic [SEL_W-1:0] accSel,
  output strobes_t         strb
);
  logic doWrite;
  logic doRead;

  assign doWrite = accEn & accWr;
  assign doRead  = accEn & ~accWr;

  always_comb begin
    strb        = '0;
    strb.wrRise = doWrite && (accSel == SEL_RISE);
    strb.wrFall = doWrite && (accSel == SEL_FALL);
    strb.wrEna  = doWrite && (accSel == SEL_ENA);
    strb.clrEvt = doRead  && (accSel == SEL_EVT);
  end
endmodule

// File: rtl/evt_status_dp.sv
module evt_status_dp
  import evt_status_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] statusIn,
  input  strobes_t         strb,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] condQ,
  output logic [WIDTH-1:0] riseQ,
  output logic [WIDTH-1:0] fallQ,
  output logic [WIDTH-1:0] evtQ,
  output logic [WIDTH-1:0] enaQ,
  output logic             sumOut
);
  localparam logic [WIDTH-1:0] LIVE_MASK = {1'b0, {(WIDTH-1){1'b1}}};

  logic [WIDTH-1:0] condNext;
  logic [WIDTH-1:0] hitBits;
  logic [WIDTH-1:0] evtKeep;

  assign condNext = statusIn & LIVE_MASK;

  // one filtered edge detector per status bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic goesUp;
    logic goesDown;
    assign goesUp     = condNext[b] & ~condQ[b];
    assign goesDown   = ~condNext[b] & condQ[b];
    assign hitBits[b] = (goesUp & riseQ[b]) | (goesDown & fallQ[b]);
  end

  // clear first, then merge new hits so a same-edge event survives
  assign evtKeep = strb.clrEvt ? '0 : evtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condQ <= '0;
      riseQ <= LIVE_MASK;
      fallQ <= '0;
      enaQ  <= '0;
      evtQ  <= '0;
    end else begin
      condQ <= condNext;
      if (strb.wrRise) riseQ <= wdata & LIVE_MASK;
      if (strb.wrFall) fallQ <= wdata & LIVE_MASK;
      if (strb.wrEna)  enaQ  <= wdata & LIVE_MASK;
      evtQ <= (evtKeep | hitBits) & LIVE_MASK;
    end
  end

  assign sumOut = |(evtQ & enaQ);
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_status_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] statusIn,
  input  logic             accEn,
  input  logic             accWr,
  input  logic [2:0]       accSel,
  input  logic [WIDTH-1:0] accWdata,
  output logic [WIDTH-1:0] accRdata,
  output logic             sumOut
);
  strobes_t         strb;
  logic [WIDTH-1:0] condQ;
  logic [WIDTH-1:0] riseQ;
  logic [WIDTH-1:0] fallQ;
  logic [WIDTH-1:0] evtQ;
  logic [WIDTH-1:0] enaQ;

  evt_status_ctrl u_ctrl (
    .accEn (accEn),
    .accWr (accWr),
    .accSel(accSel),
    .strb  (strb)
  );

  evt_status_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .statusIn(statusIn),
    .strb    (strb),
    .wdata   (accWdata),
    .condQ   (condQ),
    .riseQ   (riseQ),
    .fallQ   (fallQ),
    .evtQ    (evtQ),
    .enaQ    (enaQ),
    .sumOut  (sumOut)
  );

  always_comb begin
    case (accSel)
      SEL_COND: accRdata = condQ;
      SEL_RISE: accRdata = riseQ;
      SEL_FALL: accRdata = fallQ;
      SEL_EVT:  accRdata = evtQ;
      SEL_ENA:  accRdata = enaQ;
      default:  accRdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] statusIn,
  input logic             accEn,
  input logic             accWr,
  input logic [2:0]       accSel,
  input logic [WIDTH-1:0] accRdata,
  input logic             sumOut,
  input logic [WIDTH-1:0] condQ,
  input logic [WIDTH-1:0] riseQ,
  input logic [WIDTH-1:0] fallQ,
  input logic [WIDTH-1:0] evtQ,
  input logic [WIDTH-1:0] enaQ
);
  localparam logic [WIDTH-1:0] LIVE_MASK = {1'b0, {(WIDTH-1){1'b1}}};

  logic             armed;
  logic             readEvt;
  logic [WIDTH-1:0] inMasked;
  logic [WIDTH-1:0] upHits;
  logic [WIDTH-1:0] downHits;

  assign readEvt  = accEn && !accWr && (accSel == 3'd3);
  assign inMasked = statusIn & LIVE_MASK;
  assign upHits   = inMasked & ~condQ & riseQ;
  assign downHits = ~inMasked & condQ & fallQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_COND_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (condQ == ($past(statusIn) & LIVE_MASK))); // R1

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (upHits != '0) |=> ((evtQ & $past(upHits)) == $past(upHits))); // R2

  AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (downHits != '0) |=> ((evtQ & $past(downHits)) == $past(downHits))); // R3

  AST_NO_UNFILTERED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((evtQ & ~$past(evtQ) & ~$past(upHits | downHits)) == '0)); // R4

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !readEvt |=> ((evtQ & $past(evtQ)) == $past(evtQ))); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    readEvt |=> ((evtQ & ~$past(upHits | downHits)) == '0)); // R6

  AST_SUM_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enaQ == '0) |-> !sumOut); // R7

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !accRdata[WIDTH-1] && !riseQ[WIDTH-1] && !fallQ[WIDTH-1] && !enaQ[WIDTH-1]); // R9
endmodule

bind evt_status_reg evt_status_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .statusIn(statusIn),
  .accEn   (accEn),
  .accWr   (accWr),
  .accSel  (accSel),
  .accRdata(accRdata),
  .sumOut  (sumOut),
  .condQ   (condQ),
  .riseQ   (riseQ),
  .fallQ   (fallQ),
  .evtQ    (evtQ),
  .enaQ    (enaQ)
);

// File: tb/evt_status_reg_bench.sv
module evt_status_reg_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] statusIn = '0;
  logic         accEn = 1'b0;
  logic         accWr = 1'b0;
  logic [2:0]   accSel = '0;
  logic [W-1:0] accWdata = '0;
  logic [W-1:0] accRdata;
  logic         sumOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  evt_status_reg #(.WIDTH(W)) u_evt_status_reg (
    .clk(clk), .rstN(rstN), .statusIn(statusIn), .accEn(accEn), .accWr(accWr),
    .accSel(accSel), .accWdata(accWdata), .accRdata(accRdata), .sumOut(sumOut)
  );

  // fields: rise, fall, ena, start, end, expected event, expected sum
  localparam logic [96:0] VEC [0:7] = '{
    {16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 16'h00FF, 16'h00FF, 1'b1},
    {16'h0000, 16'hFFFF, 16'h0000, 16'h0F0F, 16'h0000, 16'h0F0F, 1'b0},
    {16'h00F0, 16'h000F, 16'h1000, 16'h000F, 16'h00F0, 16'h00FF, 1'b0},
    {16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h7FFF, 16'h0000, 1'b0},
    {16'h8000, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 1'b0},
    {16'h5555, 16'hAAAA, 16'h4000, 16'h0000, 16'h5555, 16'h5555, 1'b1},
    {16'h7FFF, 16'h7FFF, 16'h0002, 16'h1234, 16'h4321, 16'h5115, 1'b0},
    {16'hFFFF, 16'hFFFF, 16'h0004, 16'hFFFF, 16'h0000, 16'h7FFF, 1'b1}
  };

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, output logic [W-1:0] data);
    @(negedge clk);
    accEn = 1'b1; accWr = 1'b0; accSel = sel;
    #2 data = accRdata;
    @(negedge clk);
    accEn = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [W-1:0] data);
    @(negedge clk);
    accEn = 1'b1; accWr = 1'b1; accSel = sel; accWdata = data;
    @(negedge clk);
    accEn = 1'b0; accWr = 1'b0;
  endtask

  task automatic setIn(input logic [W-1:0] v);
    @(negedge clk);
    statusIn = v;
    @(negedge clk);
  endtask

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [W-1:0] got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8 reset state
    rd(3'd0, got); check("R8 cond", got, 16'h0000);
    rd(3'd1, got); check("R8 rise", got, 16'h7FFF);
    rd(3'd2, got); check("R8 fall", got, 16'h0000);
    rd(3'd4, got); check("R8 ena", got, 16'h0000);
    rd(3'd3, got); check("R8 evt", got, 16'h0000);
    check("R8 sum", {15'd0, sumOut}, 16'h0000);

    // table walk: R2 R3 R4 R7 R9
    for (int i = 0; i < 8; i++) begin
      logic [96:0] v;
      v = VEC[i];
      setIn(v[48:33]);
      setIn(v[48:33]);
      rd(3'd3, got);
      wr(3'd1, v[96:81]);
      wr(3'd2, v[80:65]);
      wr(3'd4, v[64:49]);
      setIn(v[32:17]);
      check($sformatf("R7 sum vec%0d", i), {15'd0, sumOut}, {15'd0, v[0]});
      rd(3'd3, got);
      check($sformatf("R2 R3 R4 evt vec%0d", i), got, v[16:1]);
    end

    // R9 top bit of enable cannot be set
    wr(3'd4, 16'hFFFF);
    rd(3'd4, got); check("R9 ena top bit", got, 16'h7FFF);

    // R1 condition one edge after input
    setIn(16'h0000);
    @(negedge clk);
    statusIn = 16'h9ABC; accEn = 1'b1; accWr = 1'b0; accSel = 3'd0;
    #2 check("R1 cond before edge", accRdata, 16'h0000);
    @(negedge clk);
    #2 check("R1 cond after edge", accRdata, 16'h1ABC);
    accEn = 1'b0;

    // R6 clearing read with a same-edge event
    wr(3'd1, 16'h7FFF); wr(3'd2, 16'h0000); wr(3'd4, 16'h0000);
    setIn(16'h0000);
    rd(3'd3, got);
    setIn(16'h0001);
    @(negedge clk);
    accEn = 1'b1; accWr = 1'b0; accSel = 3'd3; statusIn = 16'h0003;
    #2 check("R6 read value", accRdata, 16'h0001);
    @(negedge clk);
    accEn = 1'b0;
    rd(3'd3, got); check("R6 same-edge event kept", got, 16'h0002);
    rd(3'd3, got); check("R6 cleared after read", got, 16'h0000);

    // R5 sticky through unfiltered activity, R4 no stray bits
    wr(3'd1, 16'h0001);
    setIn(16'h0000);
    rd(3'd3, got);
    setIn(16'h0001);
    setIn(16'h0F00);
    setIn(16'h0F01);
    setIn(16'h0000);
    rd(3'd3, got); check("R5 R4 sticky event", got, 16'h0001);

    // R7 summary follows enable writes
    wr(3'd1, 16'h7FFF);
    setIn(16'h0000);
    rd(3'd3, got);
    setIn(16'h0008);
    check("R7 sum masked", {15'd0, sumOut}, 16'h0000);
    wr(3'd4, 16'h0008);
    check("R7 sum enabled", {15'd0, sumOut}, 16'h0001);
    wr(3'd4, 16'h0000);
    check("R7 sum disabled", {15'd0, sumOut}, 16'h0000);

    // R10 ignored writes and unused selectors
    wr(3'd0, 16'h1111);
    rd(3'd0, got); check("R10 cond write ignored", got, 16'h0008);
    wr(3'd3, 16'h0000);
    rd(3'd3, got); check("R10 evt write ignored", got, 16'h0008);
    wr(3'd6, 16'h0000);
    rd(3'd1, got); check("R10 unused write ignored", got, 16'h7FFF);
    rd(3'd5, got); check("R10 unused read zero", got, 16'h0000);

    finishRun();
  end
endmodule